// File: doc/BRIEF.md
# Prefixed Bit-Manipulation Execution Unit

This unit executes the second byte of a two-byte prefixed instruction against a single 8-bit operand. The operand has already been read by the surrounding pipeline, either from a register-file read port or from memory at the address held in the HL register pair. The unit splits the instruction byte into three fields. The top two bits pick an operation group. The middle three bits pick a sub-operation or a bit index. The low three bits name the operand source. From these the unit computes the result byte, the new flag byte, whether and where the result is written back, and how many machine cycles the instruction costs.

The caller presents the instruction byte, the operand and the current flag byte, and pulses `start` for one cycle. One clock later the registered outputs are valid and `done` is high for exactly one cycle. The outputs keep their values until the next accepted request. Instruction fetch, memory sequencing and the register file itself are outside this unit.

Flag byte layout: bit 7 is Zero, bit 6 is Subtract, bit 5 is Half-carry and bit 4 is Carry.

Top module: `bitop_unit`

## Requirements
- R1: The instruction byte is split as group = bits [7:6], index = bits [5:3] and selector = bits [2:0]. Selector value 6 means the memory operand; every other selector value means the register with that number.
- R2: In group 0, index 0 rotates left circular and index 1 rotates right circular. The bit that leaves the byte goes to Carry and also wraps into the opposite end.
- R3: In group 0, index 2 rotates left through carry and index 3 rotates right through carry. The incoming Carry fills the vacated bit, and the bit that leaves the byte becomes the new Carry.
- R4: In group 0, index 4 shifts left and fills bit 0 with 0. Index 5 shifts right and keeps bit 7. Index 7 shifts right and fills bit 7 with 0. In all three, the bit shifted out goes to Carry.
- R5: In group 0, index 6 exchanges the two nibbles and clears Carry.
- R6: Every group-0 operation clears Subtract and Half-carry, and sets Zero exactly when the result is 0.
- R7: Group 1 tests bit `index` of the operand. It sets Zero when that bit is 0, sets Half-carry, clears Subtract, keeps Carry, returns the operand unchanged as the result and requests no write-back.
- R8: Group 2 clears bit `index` and group 3 sets bit `index`. Both keep flag bits [7:4] unchanged.
- R9: Groups 0, 2 and 3 assert `wb_en` together with `done`. The write-back target is memory (`wb_mem`=1) when the selector is 6; otherwise `wb_reg` carries the selector.
- R10: The cycle count is 8 for a register operand and 16 for a memory operand, except that a group-1 test on memory costs 12.
- R11: Bits [3:0] of `flags_out` are always 0, whatever is on `flags_in`.
- R12: After reset all outputs are 0. A request accepted on a clock edge produces `done`=1 for exactly the following cycle, and the registered outputs hold until the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe; inputs are captured on this edge |
| opcode | input | 8 | Second byte of the prefixed instruction |
| operand | input | 8 | Operand value from a register or memory |
| flags_in | input | 8 | Current flag byte |
| result | output | 8 | Result byte |
| flags_out | output | 8 | New flag byte |
| wb_en | output | 1 | Write-back request, valid with done |
| wb_mem | output | 1 | Write-back goes to memory |
| wb_reg | output | 3 | Register index for write-back |
| cycles | output | 5 | Instruction cycle cost |
| done | output | 1 | One-cycle result-valid pulse |

## Verification
The unit holds state only in its output register, so a wrong internal value shows up in the very next cycle. It appears as a wrong result, flag byte, target or cost while `done` is high, or as `done` staying high for more than one cycle. A decode fault in one field shows up as a whole family of opcodes failing together. A wrong mux select shows up as a rotate that ignores Carry or as a bit operation that hits a neighbouring bit. The sweep covers every instruction byte with operands that have edge bits, nibble boundaries and the zero value, each under both Carry states. Every such fault therefore reaches a port on the first request that exercises it.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

   typedef enum logic [1:0] {
      GRP_SHIFT = 2'd0,
      GRP_TEST  = 2'd1,
      GRP_CLR   = 2'd2,
      GRP_SET   = 2'd3
   } grp_e;

   typedef enum logic [2:0] {
      SH_ROL_C  = 3'd0,
      SH_ROR_C  = 3'd1,
      SH_ROL_T  = 3'd2,
      SH_ROR_T  = 3'd3,
      SH_SHL    = 3'd4,
      SH_SHR_A  = 3'd5,
      SH_SWAP   = 3'd6,
      SH_SHR_L  = 3'd7
   } shop_e;

   localparam int FLAG_W = 8;
   localparam int F_ZERO = 7;
   localparam int F_SUB  = 6;
   localparam int F_HALF = 5;
   localparam int F_CARRY = 4;

endpackage

// File: rtl/bitop_decode.sv
module bitop_decode
   import bitop_pkg::*;
#(
   parameter int IDX_W   = 3,
   parameter int SEL_W   = 3,
   parameter int MEM_SEL = 6,
   localparam int OP_W   = 2 + IDX_W + SEL_W
) (
   input  logic [OP_W-1:0]  op_byte,
   output grp_e             grp,
   output logic [IDX_W-1:0] idx,
   output logic [SEL_W-1:0] sel,
   output logic             is_mem,
   output logic             writes
);

   if (MEM_SEL >= (1 << SEL_W)) begin : g_bad_sel
      $error("MEM_SEL must fit in the selector field");
   end

   always_comb begin
      grp    = grp_e'(op_byte[OP_W-1 -: 2]);
      idx    = op_byte[SEL_W +: IDX_W];
      sel    = op_byte[SEL_W-1:0];
      is_mem = (sel == SEL_W'(MEM_SEL));
      writes = (grp != GRP_TEST);
   end

endmodule

// File: rtl/bitop_shift.sv
module bitop_shift
   import bitop_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  shop_e              op,
   input  logic [DATA_W-1:0]  val,
   input  logic               cin,
   output logic [DATA_W-1:0]  res,
   output logic               cout
);

   localparam int HALF_W = DATA_W / 2;

   if ((DATA_W % 2) != 0 || DATA_W < 4) begin : g_bad_w
      $error("shift unit needs an even width of at least 4");
   end

   logic msb, lsb;
   assign msb = val[DATA_W-1];
   assign lsb = val[0];

   always_comb begin
      res  = val;
      cout = 1'b0;
      unique case (op)
         SH_ROL_C: begin res = {val[DATA_W-2:0], msb};  cout = msb; end
         SH_ROR_C: begin res = {lsb, val[DATA_W-1:1]};  cout = lsb; end
         SH_ROL_T: begin res = {val[DATA_W-2:0], cin};  cout = msb; end
         SH_ROR_T: begin res = {cin, val[DATA_W-1:1]};  cout = lsb; end
         SH_SHL:   begin res = {val[DATA_W-2:0], 1'b0}; cout = msb; end
         SH_SHR_A: begin res = {msb, val[DATA_W-1:1]};  cout = lsb; end
         SH_SWAP:  begin res = {val[HALF_W-1:0], val[DATA_W-1:HALF_W]}; cout = 1'b0; end
         SH_SHR_L: begin res = {1'b0, val[DATA_W-1:1]}; cout = lsb; end
         default:  begin res = val; cout = 1'b0; end
      endcase
   end

endmodule

// File: rtl/bitop_bitfield.sv
module bitop_bitfield #(
   parameter int DATA_W = 8,
   localparam int IDX_W = $clog2(DATA_W)
) (
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] val,
   output logic [DATA_W-1:0] cleared,
   output logic [DATA_W-1:0] setv,
   output logic              picked
);

   logic [DATA_W-1:0] mask;

   for (genvar i = 0; i < DATA_W; i++) begin : g_mask
      assign mask[i] = (idx == IDX_W'(i));
   end

   assign cleared = val & ~mask;
   assign setv    = val | mask;
   assign picked  = |(val & mask);

endmodule

// File: rtl/bitop_cost.sv
module bitop_cost
   import bitop_pkg::*;
#(
   parameter int CYC_W        = 5,
   parameter int REG_CYC      = 8,
   parameter int MEM_CYC      = 16,
   parameter int MEM_TEST_CYC = 12
) (
   input  grp_e             grp,
   input  logic             is_mem,
   output logic [CYC_W-1:0] cycles
);

   if (MEM_CYC >= (1 << CYC_W) || REG_CYC >= (1 << CYC_W) ||
       MEM_TEST_CYC >= (1 << CYC_W)) begin : g_bad_cyc
      $error("cycle costs must fit in CYC_W bits");
   end

   always_comb begin
      if (!is_mem)
         cycles = CYC_W'(REG_CYC);
      else if (grp == GRP_TEST)
         cycles = CYC_W'(MEM_TEST_CYC);
      else
         cycles = CYC_W'(MEM_CYC);
   end

endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
   import bitop_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int SEL_W        = 3,
   parameter int MEM_SEL      = 6,
   parameter int CYC_W        = 5,
   parameter int REG_CYC      = 8,
   parameter int MEM_CYC      = 16,
   parameter int MEM_TEST_CYC = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [7:0]        opcode,
   input  logic [DATA_W-1:0] operand,
   input  logic [7:0]        flags_in,
   output logic [DATA_W-1:0] result,
   output logic [7:0]        flags_out,
   output logic              wb_en,
   output logic              wb_mem,
   output logic [SEL_W-1:0]  wb_reg,
   output logic [CYC_W-1:0]  cycles,
   output logic              done
);

   localparam int IDX_W = $clog2(DATA_W);
   localparam int OP_W  = 2 + IDX_W + SEL_W;

   if (OP_W != 8) begin : g_bad_op
      $error("group, index and selector fields must fill one byte");
   end
   if (DATA_W != 8) begin : g_bad_data
      $error("the flag layout assumes an 8-bit operand");
   end

   grp_e             grp;
   logic [IDX_W-1:0] idx;
   logic [SEL_W-1:0] sel;
   logic             is_mem, writes;

   bitop_decode #(.IDX_W(IDX_W), .SEL_W(SEL_W), .MEM_SEL(MEM_SEL)) u_dec (
      .op_byte (opcode),
      .grp     (grp),
      .idx     (idx),
      .sel     (sel),
      .is_mem  (is_mem),
      .writes  (writes)
   );

   logic [DATA_W-1:0] sh_res;
   logic              sh_cout;

   bitop_shift #(.DATA_W(DATA_W)) u_shift (
      .op   (shop_e'(idx)),
      .val  (operand),
      .cin  (flags_in[F_CARRY]),
      .res  (sh_res),
      .cout (sh_cout)
   );

   logic [DATA_W-1:0] bf_clr, bf_set;
   logic              bf_bit;

   bitop_bitfield #(.DATA_W(DATA_W)) u_bits (
      .idx     (idx),
      .val     (operand),
      .cleared (bf_clr),
      .setv    (bf_set),
      .picked  (bf_bit)
   );

   logic [CYC_W-1:0] cyc_d;

   bitop_cost #(
      .CYC_W(CYC_W), .REG_CYC(REG_CYC), .MEM_CYC(MEM_CYC),
      .MEM_TEST_CYC(MEM_TEST_CYC)
   ) u_cost (
      .grp    (grp),
      .is_mem (is_mem),
      .cycles (cyc_d)
   );

   logic [DATA_W-1:0] res_d;
   logic [7:0]        flg_d;

   always_comb begin
      res_d = operand;
      flg_d = {flags_in[7:4], 4'b0000};
      unique case (grp)
         GRP_SHIFT: begin
            res_d = sh_res;
            flg_d = 8'h00;
            flg_d[F_ZERO]  = (sh_res == '0);
            flg_d[F_CARRY] = sh_cout;
         end
         GRP_TEST: begin
            res_d = operand;
            flg_d = 8'h00;
            flg_d[F_ZERO]  = ~bf_bit;
            flg_d[F_HALF]  = 1'b1;
            flg_d[F_CARRY] = flags_in[F_CARRY];
         end
         GRP_CLR: res_d = bf_clr;
         GRP_SET: res_d = bf_set;
         default: res_d = operand;
      endcase
   end

   logic wen_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done      <= 1'b0;
         result    <= '0;
         flags_out <= '0;
         wen_q     <= 1'b0;
         wb_mem    <= 1'b0;
         wb_reg    <= '0;
         cycles    <= '0;
      end else begin
         done <= start;
         if (start) begin
            result    <= res_d;
            flags_out <= flg_d;
            wen_q     <= writes;
            wb_mem    <= is_mem;
            wb_reg    <= sel;
            cycles    <= cyc_d;
         end
      end
   end

   assign wb_en = done & wen_q;

   // R12: done only follows an accepted request
   a_r12_done_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(start));

   // R11: the low nibble of the flag output stays clear
   a_r11_low_nibble_zero: assert property (@(posedge clk) disable iff (!rst_n)
      flags_out[3:0] == 4'h0);

   // R7: a bit test never requests write-back
   a_r7_test_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (done && $past(opcode[7:6] == 2'b01)) |-> !wb_en);

   // R8: clear and set keep the upper flag nibble
   a_r8_flags_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (done && $past(opcode[7])) |-> flags_out[7:4] == $past(flags_in[7:4]));

   // R10: cost is one of the three legal values
   a_r10_cost_legal: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (cycles == CYC_W'(REG_CYC) || cycles == CYC_W'(MEM_CYC) ||
                cycles == CYC_W'(MEM_TEST_CYC)));

   // R12: outputs hold while no request arrives
   a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(start) && !$past(!rst_n)) |-> ($stable(result) && $stable(flags_out)));

endmodule

// File: tb/bitop_unit_bench.sv
`timescale 1ns/1ps
module bitop_unit_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [7:0] opcode = 8'h00;
   logic [7:0] operand = 8'h00;
   logic [7:0] flags_in = 8'h00;
   logic [7:0] result, flags_out;
   logic       wb_en, wb_mem, done;
   logic [2:0] wb_reg;
   logic [4:0] cycles;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   bitop_unit u_bitop_unit (
      .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
      .operand(operand), .flags_in(flags_in), .result(result),
      .flags_out(flags_out), .wb_en(wb_en), .wb_mem(wb_mem),
      .wb_reg(wb_reg), .cycles(cycles), .done(done)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h (op=%02h val=%02h f=%02h)",
                  tag, act, exp, opcode, operand, flags_in);
      end
   endtask

   logic [7:0] e_res, e_flg;
   logic       e_wen;
   logic [4:0] e_cyc;
   string      t_res, t_flg;

   task automatic model(input logic [7:0] op, input logic [7:0] v, input logic [7:0] f);
      logic [1:0] g;
      logic [2:0] k, s;
      logic       c, co;
      g = op[7:6]; k = op[5:3]; s = op[2:0]; c = f[4];
      e_res = v; e_flg = {f[7:4], 4'h0}; e_wen = (g != 2'd1); co = 1'b0;
      e_cyc = (s != 3'd6) ? 5'd8 : (g == 2'd1 ? 5'd12 : 5'd16);
      case (g)
         2'd0: begin
            case (k)
               3'd0: begin co = v[7]; e_res = (v << 1) | (v >> 7); t_res = "R2"; end
               3'd1: begin co = v[0]; e_res = (v >> 1) | (v << 7); t_res = "R2"; end
               3'd2: begin co = v[7]; e_res = (v << 1) | {7'd0, c}; t_res = "R3"; end
               3'd3: begin co = v[0]; e_res = (v >> 1) | {c, 7'd0}; t_res = "R3"; end
               3'd4: begin co = v[7]; e_res = v << 1; t_res = "R4"; end
               3'd5: begin co = v[0]; e_res = (v >> 1) | (v & 8'h80); t_res = "R4"; end
               3'd6: begin co = 1'b0; e_res = {v[3:0], v[7:4]}; t_res = "R5"; end
               default: begin co = v[0]; e_res = v >> 1; t_res = "R4"; end
            endcase
            e_flg = {(e_res == 8'h00), 1'b0, 1'b0, co, 4'h0};
            t_flg = (k == 3'd6) ? "R5" : "R6";
         end
         2'd1: begin
            e_flg = {~v[k], 1'b0, 1'b1, c, 4'h0};
            t_res = "R7"; t_flg = "R7";
         end
         2'd2: begin e_res = v & ~(8'h01 << k); t_res = "R8"; t_flg = "R8"; end
         default: begin e_res = v | (8'h01 << k); t_res = "R8"; t_flg = "R8"; end
      endcase
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL R12 watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
         $finish;
      end
   end

   localparam logic [7:0] VALS [8] = '{8'h00, 8'h01, 8'h80, 8'hFF,
                                       8'h0F, 8'hF0, 8'hA5, 8'h5A};

   initial begin : main
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R12: reset state
      chk("R12 reset done", done, 0);
      chk("R12 reset result", result, 0);
      chk("R12 reset flags", flags_out, 0);
      chk("R12 reset wb_en", wb_en, 0);
      chk("R12 reset cycles", cycles, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R12 idle done", done, 0);

      for (int op = 0; op < 256; op++) begin
         for (int vi = 0; vi < 8; vi++) begin
            for (int ci = 0; ci < 2; ci++) begin
               @(negedge clk);
               opcode   = 8'(op);
               operand  = VALS[vi];
               flags_in = {~ci[0], ci[0], ~ci[0], ci[0], 4'b1011};
               start    = 1'b1;
               model(opcode, operand, flags_in);
               @(negedge clk);
               start = 1'b0;
               chk("R12 done pulse", done, 1);
               chk(t_res, result, e_res);
               chk(t_flg, flags_out, e_flg);
               chk("R11 low nibble", flags_out[3:0], 0);
               chk("R9 wb_en", wb_en, e_wen);
               chk("R1 memory select", wb_mem, (opcode[2:0] == 3'd6));
               if (e_wen && opcode[2:0] != 3'd6) chk("R9 wb_reg", wb_reg, opcode[2:0]);
               chk("R10 cycles", cycles, e_cyc);
               // hold cycle with scrambled inputs
               operand  = ~operand;
               flags_in = ~flags_in;
               opcode   = ~opcode;
               @(negedge clk);
               chk("R12 done drops", done, 0);
               chk("R12 result held", result, e_res);
               chk("R12 flags held", flags_out, e_flg);
               chk("R12 no write when idle", wb_en, 0);
            end
         end
      end

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

endmodule